// File: doc/BRIEF.md
# Load/Store Byte-Reversing Data Formatter

This block sits between a 64-bit register value and the memory data bus of a load/store unit. For a load it takes the raw bytes returned from memory, with the accessed item right-aligned, and produces the register result. It extends a 1, 2 or 4 byte item to 64 bits with zeros or with copies of its sign bit. When asked, it first reverses the byte order inside a 2, 4 or 8 byte item. For a store it takes the source register, keeps the low 1, 2, 4 or 8 bytes, reverses their order if asked, and produces right-aligned store data together with a byte-lane enable mask.

Each request is presented for one cycle with a valid strobe. The formatted result appears one clock later with its own valid. Combinations that have no meaning raise an illegal flag instead of producing data. Address alignment, caching and floating-point format conversion happen elsewhere in the pipeline.

Top module: `mem_data_formatter`

## Requirements
- R1: A request sampled with `in_valid_i` high at a rising clock edge produces `out_valid_o` high after that edge. With `in_valid_i` low, `out_valid_o` goes low and every data output, `byte_en_o` and `illegal_o` hold their previous values.
- R2: The size code is 00 for byte, 01 for halfword, 10 for word and 11 for doubleword. A load with sign extension off returns the low 8, 16, 32 or 64 bits of `mem_data_i` in the low bits of `load_data_o`, and all bits above the item are 0.
- R3: A load with sign extension on, of a byte, halfword or word, fills every bit of `load_data_o` above the item with the item's most significant bit.
- R4: A byte-reversed load of a halfword, word or doubleword returns the item with its bytes in reverse order: byte k of the result is byte (N-1-k) of the item, where N is the item size in bytes. The bits above the item are 0.
- R5: A store returns the low 8, 16, 32 or 64 bits of `src_data_i` in the low bits of `store_data_o`, and all bits above the item are 0.
- R6: A byte-reversed store of a halfword, word or doubleword reverses the byte order across the item. The least significant byte of the source appears in the top byte lane of the item.
- R7: For a store, bits 0 to N-1 of `byte_en_o` are set and the rest are clear, where N is 1, 2, 4 or 8 from the size code. For a load, `byte_en_o` is all zeros.
- R8: A request is illegal if byte reversal is requested with byte size, or if sign extension is requested together with byte reversal or with doubleword size. An illegal request sets `illegal_o` and drives `load_data_o`, `store_data_o` and `byte_en_o` to zero. A legal request clears `illegal_o`.
- R9: A load drives `store_data_o` to zero, and a store drives `load_data_o` to zero.
- R10: On a legal store of a byte, halfword or word without byte reversal, the sign-extension flag has no effect on the outputs.
- R11: While reset is asserted and after it is released, `out_valid_o`, `illegal_o` and all data and enable outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| size_i | input | 2 | Access size code: 00 byte, 01 halfword, 10 word, 11 doubleword |
| store_i | input | 1 | 1 for a store, 0 for a load |
| sext_i | input | 1 | Sign-extend the loaded item |
| brev_i | input | 1 | Reverse the byte order within the item |
| mem_data_i | input | 64 | Raw load data, item right-aligned |
| src_data_i | input | 64 | Store source register value |
| out_valid_o | output | 1 | Result valid |
| load_data_o | output | 64 | Formatted load result |
| store_data_o | output | 64 | Right-aligned store data |
| byte_en_o | output | 8 | Store byte-lane enables |
| illegal_o | output | 1 | Request combination is illegal |

## Verification
Byte reversal and sign extension can be requested in the same cycle. Byte reversal is also handed to the same data path as the store formatting. The bench issues requests that set both flags on halfword and word loads, and on a reversed store. It expects every data output and the enables to be zero with `illegal_o` set. It then shows that the sign flag alone, on a non-reversed store, leaves the store data and mask exactly as they would be without it. Requests are also issued back to back, a load followed directly by a store, so that one cycle's result cannot leak into the next.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_H = 2'b01,
    SZ_W = 2'b10,
    SZ_D = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic      is_store;
    logic      ext_sign;
    logic      rev;
    acc_size_e size;
    logic      illegal;
  } fmt_ctl_t;

endpackage

// File: rtl/mdf_decode.sv
module mdf_decode
  import mdf_pkg::*;
(
  input  logic      store_i,
  input  logic      sext_i,
  input  logic      brev_i,
  input  acc_size_e size_i,
  output fmt_ctl_t  ctl_o
);

  logic rev_on_byte;
  logic sext_bad;

  assign rev_on_byte = brev_i && (size_i == SZ_B);
  assign sext_bad    = sext_i && (brev_i || (size_i == SZ_D));

  always_comb begin
    ctl_o.is_store = store_i;
    // sign fill only meaningful on loads
    ctl_o.ext_sign = sext_i && !store_i;
    ctl_o.rev      = brev_i;
    ctl_o.size     = size_i;
    ctl_o.illegal  = rev_on_byte || sext_bad;
  end

endmodule

// File: rtl/mdf_swap.sv
module mdf_swap
  import mdf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] din_i,
  input  acc_size_e         size_i,
  output logic [DATA_W-1:0] dout_o
);

  localparam int NB  = DATA_W / 8;
  localparam int NSZ = $clog2(NB) + 1;

  logic [DATA_W-1:0] cand [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int W = 1 << s;
    for (genvar b = 0; b < NB; b++) begin : g_b
      if (b < W) begin : g_in
        assign cand[s][8*b +: 8] = din_i[8*(W-1-b) +: 8];
      end else begin : g_out
        assign cand[s][8*b +: 8] = 8'h00;
      end
    end
  end

  assign dout_o = cand[size_i];

endmodule

// File: rtl/mdf_extend.sv
module mdf_extend
  import mdf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] din_i,
  input  acc_size_e         size_i,
  input  logic              sign_i,
  output logic [DATA_W-1:0] dout_o
);

  localparam int NB  = DATA_W / 8;
  localparam int NSZ = $clog2(NB) + 1;

  logic [DATA_W-1:0] cand [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int KB = 8 << s;
    if (KB >= DATA_W) begin : g_full
      assign cand[s] = din_i;
    end else begin : g_part
      assign cand[s] = {{(DATA_W-KB){sign_i & din_i[KB-1]}}, din_i[KB-1:0]};
    end
  end

  assign dout_o = cand[size_i];

endmodule

// File: rtl/mdf_lanes.sv
module mdf_lanes
  import mdf_pkg::*;
#(
  parameter int NB = 8
) (
  input  acc_size_e     size_i,
  output logic [NB-1:0] mask_o
);

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      mask_o[b] = (b < (1 << size_i));
    end
  end

endmodule

// File: rtl/mem_data_formatter.sv
module mem_data_formatter
  import mdf_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        size_i,
  input  logic              store_i,
  input  logic              sext_i,
  input  logic              brev_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic [DATA_W-1:0] store_data_o,
  output logic [NB-1:0]     byte_en_o,
  output logic              illegal_o
);

  fmt_ctl_t          ctl;
  acc_size_e         size_in;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] item;
  logic [DATA_W-1:0] formatted;
  logic [NB-1:0]     lane_mask;

  assign size_in = acc_size_e'(size_i);

  mdf_decode u_decode (
    .store_i (store_i),
    .sext_i  (sext_i),
    .brev_i  (brev_i),
    .size_i  (size_in),
    .ctl_o   (ctl)
  );

  // single shared path: operand picked by direction
  assign operand = ctl.is_store ? src_data_i : mem_data_i;

  mdf_swap #(.DATA_W(DATA_W)) u_swap (
    .din_i  (operand),
    .size_i (ctl.size),
    .dout_o (swapped)
  );

  assign item = ctl.rev ? swapped : operand;

  mdf_extend #(.DATA_W(DATA_W)) u_extend (
    .din_i  (item),
    .size_i (ctl.size),
    .sign_i (ctl.ext_sign),
    .dout_o (formatted)
  );

  mdf_lanes #(.NB(NB)) u_lanes (
    .size_i (ctl.size),
    .mask_o (lane_mask)
  );

  logic      vld_q;
  logic      st_q;
  logic      sx_q;
  acc_size_e sz_q;
  logic      ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q        <= 1'b0;
      st_q         <= 1'b0;
      sx_q         <= 1'b0;
      sz_q         <= SZ_B;
      ill_q        <= 1'b0;
      load_data_o  <= '0;
      store_data_o <= '0;
      byte_en_o    <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) begin
        st_q  <= ctl.is_store;
        sx_q  <= sext_i;
        sz_q  <= ctl.size;
        ill_q <= ctl.illegal;
        if (ctl.illegal) begin
          load_data_o  <= '0;
          store_data_o <= '0;
          byte_en_o    <= '0;
        end else if (ctl.is_store) begin
          load_data_o  <= '0;
          store_data_o <= formatted;
          byte_en_o    <= lane_mask;
        end else begin
          load_data_o  <= formatted;
          store_data_o <= '0;
          byte_en_o    <= '0;
        end
      end
    end
  end

  assign out_valid_o = vld_q;
  assign illegal_o   = ill_q;

  // R1
  p_valid_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_valid_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && $stable(load_data_o) && $stable(store_data_o)
                    && $stable(byte_en_o) && $stable(illegal_o));

  // R2
  p_zext_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !st_q && !sx_q && !ill_q) |->
      ((load_data_o >> (8 << sz_q)) == '0));

  // R3
  p_sext_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !st_q && sx_q && !ill_q) |->
      ((sz_q == SZ_B) ? (load_data_o[DATA_W-1:8]  == {(DATA_W-8){load_data_o[7]}}) :
       (sz_q == SZ_H) ? (load_data_o[DATA_W-1:16] == {(DATA_W-16){load_data_o[15]}}) :
                        (load_data_o[DATA_W-1:32] == {(DATA_W-32){load_data_o[31]}})));

  // R5
  p_store_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && st_q && !ill_q) |-> ((store_data_o >> (8 << sz_q)) == '0));

  // R7
  p_lane_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && st_q && !ill_q) |->
      ($countones(byte_en_o) == (1 << sz_q)) && byte_en_o[0]);

  // R8
  p_illegal_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && illegal_o) |->
      (load_data_o == '0) && (store_data_o == '0) && (byte_en_o == '0));

  // R9
  p_load_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !st_q) |-> (store_data_o == '0) && (byte_en_o == '0));
  p_store_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && st_q) |-> (load_data_o == '0));

endmodule

// File: tb/mem_data_formatter_tb_top.sv
`timescale 1ns/1ps
module mem_data_formatter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  size = 2'b00;
  logic        store = 1'b0;
  logic        sext = 1'b0;
  logic        brev = 1'b0;
  logic [63:0] mem_data = '0;
  logic [63:0] src_data = '0;
  logic        out_valid;
  logic [63:0] load_data;
  logic [63:0] store_data;
  logic [7:0]  byte_en;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mem_data_formatter dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .in_valid_i   (in_valid),
    .size_i       (size),
    .store_i      (store),
    .sext_i       (sext),
    .brev_i       (brev),
    .mem_data_i   (mem_data),
    .src_data_i   (src_data),
    .out_valid_o  (out_valid),
    .load_data_o  (load_data),
    .store_data_o (store_data),
    .byte_en_o    (byte_en),
    .illegal_o    (illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected outputs from the requirement text
  task automatic model(input logic st, input logic sx, input logic br,
                       input logic [1:0] sz, input logic [63:0] mem,
                       input logic [63:0] src,
                       output logic [63:0] eld, output logic [63:0] esd,
                       output logic [7:0] ebe, output logic eill);
    int nb;
    logic [63:0] op;
    logic [63:0] it;
    nb   = 1 << sz;
    eill = (br && sz == 2'b00) || (sx && (br || sz == 2'b11));
    op   = st ? src : mem;
    it   = '0;
    for (int b = 0; b < nb; b++)
      it[8*b +: 8] = br ? op[8*(nb-1-b) +: 8] : op[8*b +: 8];
    if (sx && !st && nb < 8 && it[8*nb-1])
      for (int k = 8*nb; k < 64; k++) it[k] = 1'b1;
    eld = '0; esd = '0; ebe = '0;
    if (!eill) begin
      if (st) begin
        esd = it;
        ebe = 8'((1 << nb) - 1);
      end else begin
        eld = it;
      end
    end
  endtask

  // drive at negedge, result sampled one full cycle later at negedge
  task automatic issue(input string req, input logic st, input logic sx,
                       input logic br, input logic [1:0] sz,
                       input logic [63:0] mem, input logic [63:0] src);
    logic [63:0] eld, esd;
    logic [7:0]  ebe;
    logic        eill;
    model(st, sx, br, sz, mem, src, eld, esd, ebe, eill);
    in_valid = 1'b1; store = st; sext = sx; brev = br; size = sz;
    mem_data = mem; src_data = src;
    @(posedge clk);
    @(negedge clk);
    chk(req, "out_valid", 64'(out_valid), 64'd1);
    chk(req, "load_data", load_data, eld);
    chk(req, "store_data", store_data, esd);
    chk(req, "byte_en", 64'(byte_en), 64'(ebe));
    chk(req, "illegal", 64'(illegal), 64'(eill));
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11", "out_valid", 64'(out_valid), 64'd0);
    chk("R11", "load_data", load_data, 64'd0);
    chk("R11", "store_data", store_data, 64'd0);
    chk("R11", "byte_en", 64'(byte_en), 64'd0);
    chk("R11", "illegal", 64'(illegal), 64'd0);
  endtask

  task automatic t_zext_loads();
    issue("R2", 0, 0, 0, 2'b00, 64'hFEDC_BA98_7654_32F1, 64'h0);
    issue("R2", 0, 0, 0, 2'b01, 64'hFEDC_BA98_7654_C3F1, 64'h0);
    issue("R2", 0, 0, 0, 2'b10, 64'hFEDC_BA98_8654_32F1, 64'h0);
    issue("R2", 0, 0, 0, 2'b11, 64'hFEDC_BA98_7654_32F1, 64'h0);
    idle();
  endtask

  task automatic t_sext_loads();
    issue("R3", 0, 1, 0, 2'b00, 64'h1111_2222_3333_4480, 64'h0);
    issue("R3", 0, 1, 0, 2'b00, 64'hFFFF_FFFF_FFFF_FF7F, 64'h0);
    issue("R3", 0, 1, 0, 2'b01, 64'h0000_0000_0000_8001, 64'h0);
    issue("R3", 0, 1, 0, 2'b01, 64'hFFFF_FFFF_FFFF_7FFF, 64'h0);
    issue("R3", 0, 1, 0, 2'b10, 64'h0000_0000_8765_4321, 64'h0);
    issue("R3", 0, 1, 0, 2'b10, 64'hAAAA_AAAA_1234_5678, 64'h0);
    idle();
  endtask

  task automatic t_brev_loads();
    issue("R4", 0, 0, 1, 2'b01, 64'h9999_9999_9999_A1B2, 64'h0);
    issue("R4", 0, 0, 1, 2'b10, 64'h9999_9999_A1B2_C3D4, 64'h0);
    issue("R4", 0, 0, 1, 2'b11, 64'h0102_0304_0506_0708, 64'h0);
    idle();
  endtask

  task automatic t_stores();
    issue("R5", 1, 0, 0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF);
    issue("R5", 1, 0, 0, 2'b01, 64'h0, 64'h0123_4567_89AB_CDEF);
    issue("R7", 1, 0, 0, 2'b10, 64'h0, 64'h0123_4567_89AB_CDEF);
    issue("R7", 1, 0, 0, 2'b11, 64'h0, 64'h0123_4567_89AB_CDEF);
    idle();
  endtask

  task automatic t_brev_stores();
    issue("R6", 1, 0, 1, 2'b01, 64'h0, 64'hAAAA_AAAA_AAAA_1122);
    issue("R6", 1, 0, 1, 2'b10, 64'h0, 64'hAAAA_AAAA_1122_3344);
    issue("R6", 1, 0, 1, 2'b11, 64'h0, 64'h1122_3344_5566_7788);
    idle();
  endtask

  task automatic t_illegal();
    issue("R8", 0, 0, 1, 2'b00, 64'h0000_0000_0000_00FF, 64'h0);
    issue("R8", 0, 1, 1, 2'b01, 64'h0000_0000_0000_80FF, 64'h0);
    issue("R8", 0, 1, 1, 2'b10, 64'h0000_0000_8000_00FF, 64'h0);
    issue("R8", 0, 1, 0, 2'b11, 64'h8000_0000_0000_00FF, 64'h0);
    issue("R8", 1, 0, 1, 2'b00, 64'h0, 64'h0000_0000_0000_00AB);
    issue("R8", 1, 1, 1, 2'b10, 64'h0, 64'h0000_0000_DEAD_BEEF);
    // legal after illegal clears the flag
    issue("R8", 0, 0, 0, 2'b10, 64'h0000_0000_DEAD_BEEF, 64'h0);
    idle();
  endtask

  task automatic t_sext_store_ignored();
    issue("R10", 1, 1, 0, 2'b00, 64'h0, 64'hFFFF_FFFF_FFFF_FF80);
    issue("R10", 1, 1, 0, 2'b01, 64'h0, 64'h0000_0000_0000_8000);
    issue("R10", 1, 1, 0, 2'b10, 64'h0, 64'h1234_5678_9ABC_DEF0);
    idle();
  endtask

  task automatic t_back_to_back();
    // R9: a load then a store with no gap
    issue("R9", 0, 0, 0, 2'b11, 64'h5555_6666_7777_8888, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R9", 1, 0, 0, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_1234);
    issue("R9", 0, 1, 0, 2'b00, 64'h0000_0000_0000_00C0, 64'hFFFF);
    idle();
  endtask

  task automatic t_hold();
    logic [63:0] ld0, sd0;
    logic [7:0]  be0;
    logic        il0;
    issue("R1", 1, 0, 0, 2'b10, 64'h0, 64'hCAFE_F00D_1357_9BDF);
    ld0 = load_data; sd0 = store_data; be0 = byte_en; il0 = illegal;
    in_valid = 1'b0; store = 1'b0; brev = 1'b1; sext = 1'b1; size = 2'b00;
    mem_data = 64'hFFFF_FFFF_FFFF_FFFF; src_data = 64'h0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1", "out_valid low", 64'(out_valid), 64'd0);
      chk("R1", "store_data hold", store_data, sd0);
      chk("R1", "load_data hold", load_data, ld0);
      chk("R1", "byte_en hold", 64'(byte_en), 64'(be0));
      chk("R1", "illegal hold", 64'(illegal), 64'(il0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zext_loads();
    t_sext_loads();
    t_brev_loads();
    t_stores();
    t_brev_stores();
    t_illegal();
    t_sext_store_ignored();
    t_back_to_back();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule